// File: doc/BRIEF.md
# Selectable-Rate Strobe and Hex Counter

This block divides one fast system clock into a periodic one-cycle enable strobe and uses that strobe to step a four-bit hexadecimal counter. A down-counter is loaded with a reload value picked by a two-bit rate select. It counts down to zero, raises the strobe for exactly that one cycle, and reloads. The strobe therefore repeats every reload-plus-one clocks. The counter advances by one on each strobe and rolls over from F to 0.

The rate can be switched while the block is running. A new select value only takes effect when the down-counter next reloads, so a count that is already under way always finishes at its old length. The divider and the counter each have their own synchronous active-low reset, so one can be cleared without touching the other. Every output comes from registers, and all inputs are sampled on the rising clock edge.

Top module: `rate_hex_counter`

## Requirements
- R1: When `div_rst_n` is low at a rising edge, the down-counter loads the reload value picked by the `rate_sel` present at that edge. In the following cycle `tick` is low and `count` is not changed by the divider reset.
- R2: Select code 2'b00 picks reload value 1. `tick` is high in every second cycle, and the first strobe comes in the second cycle after the divider reset.
- R3: Select code 2'b01 picks reload value 9. `tick` is high once every ten cycles, and the first strobe comes in the tenth cycle after the divider reset.
- R4: Select codes 2'b10 and 2'b11 behave exactly like 2'b00 (reload value 1).
- R5: `tick` is high for exactly one cycle at a time, in the cycles where the down-counter holds zero. In every other cycle the down-counter decreases by one.
- R6: `count` increases by one after each cycle in which `tick` is high, and holds its value otherwise.
- R7: `count` wraps from 4'hF to 4'h0 on a strobe.
- R8: When `cnt_rst_n` is low at a rising edge, `count` becomes 0 even if `tick` is high. The divider keeps running unaffected.
- R9: A change on `rate_sel` during a countdown does not alter that countdown. The new rate applies from the next reload onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rate_sel | input | 2 | Rate select code, applied at each reload |
| div_rst_n | input | 1 | Synchronous active-low reset of the down-counter |
| cnt_rst_n | input | 1 | Synchronous active-low reset of the hex counter |
| tick | output | 1 | One-cycle enable strobe, high when the down-counter is zero |
| count | output | 4 | Hexadecimal count value |

## Verification
On every cycle, the embedded properties check the following: the strobe never lasts two cycles, the down-counter only steps down by one between reloads (so a select change cannot cut a countdown short), the reload value is never zero, and the counter steps, holds or wraps according to the strobe. The bench scenarios are needed for the things a single-cycle property cannot show. These are the absolute strobe periods for each of the four select codes, the phase of the first strobe after a reset, the exact cycle where a mid-count rate change first shows, and the priority of the counter reset over a coincident strobe.

// File: rtl/rate_hex_pkg.sv
package rate_hex_pkg;

    // Rate select encoding as seen on the rate_sel input
    typedef enum logic [1:0] {
        RATE_FAST  = 2'b00,
        RATE_SLOW  = 2'b01,
        RATE_RSV_A = 2'b10,
        RATE_RSV_B = 2'b11
    } rate_code_e;

    localparam int unsigned RELOAD_FAST = 1;
    localparam int unsigned RELOAD_SLOW = 9;

    // Reload value for a select code; unknown or reserved codes fall back to fast
    function automatic int unsigned reload_of(input logic [1:0] code);
        int unsigned r;
        case (code)
            RATE_SLOW: r = RELOAD_SLOW;
            default:   r = RELOAD_FAST;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rate_decode.sv
module rate_decode
    import rate_hex_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic [1:0]       sel,
    output logic [DIV_W-1:0] reload
);

    always_comb begin
        reload = DIV_W'(reload_of(sel));
    end

    // R4: every code, including reserved ones, yields a usable nonzero reload
    always_comb begin
        assert_reload_nonzero_R4: assert (reload != '0);
    end

endmodule

// File: rtl/rate_strobe_div.sv
module rate_strobe_div #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] reload,
    output logic             strobe
);

    logic [DIV_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n || remain == '0) begin
            remain <= reload;
        end else begin
            remain <= remain - DIV_W'(1);
        end
    end

    assign strobe = (remain == '0);

    // R5: a strobe never spans two consecutive cycles
    assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    // R9: between reloads the count only steps down, whatever the select does
    assert_countdown_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (remain != '0) |=> (remain == $past(remain) - DIV_W'(1)));

endmodule

// File: rtl/hex_step_counter.sv
module hex_step_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    output logic [CNT_W-1:0] value
);

    localparam logic [CNT_W-1:0] TOP_VAL = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (step_en) begin
            value <= value + CNT_W'(1);
        end
    end

    // R6: advance by one on a strobe
    assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && value != TOP_VAL) |=> (value == $past(value) + CNT_W'(1)));

    // R6: hold without a strobe
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(value));

    // R7: roll over from the top value to zero
    assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && value == TOP_VAL) |=> (value == '0));

endmodule

// File: rtl/rate_hex_counter.sv
module rate_hex_counter #(
    parameter int DIV_W = 4,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic [1:0]       rate_sel,
    input  logic             div_rst_n,
    input  logic             cnt_rst_n,
    output logic             tick,
    output logic [CNT_W-1:0] count
);

    logic [DIV_W-1:0] reload_val;

    rate_decode #(.DIV_W(DIV_W)) u_decode (
        .sel    (rate_sel),
        .reload (reload_val)
    );

    rate_strobe_div #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (div_rst_n),
        .reload (reload_val),
        .strobe (tick)
    );

    hex_step_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (cnt_rst_n),
        .step_en (tick),
        .value   (count)
    );

endmodule

// File: tb/rate_hex_counter_tb.sv
module rate_hex_counter_tb;

    logic       clk = 1'b0;
    logic [1:0] rate_sel = 2'b00;
    logic       div_rst_n = 1'b0;
    logic       cnt_rst_n = 1'b0;
    logic       tick;
    logic [3:0] count;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rate_hex_counter u_dut (
        .clk       (clk),
        .rate_sel  (rate_sel),
        .div_rst_n (div_rst_n),
        .cnt_rst_n (cnt_rst_n),
        .tick      (tick),
        .count     (count)
    );

    task automatic check(input int act, input int exp, input string req, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Both resets for one edge; returns positioned just after that edge (k = 0)
    task automatic reset_all(input logic [1:0] s);
        @(negedge clk);
        rate_sel  = s;
        div_rst_n = 1'b0;
        cnt_rst_n = 1'b0;
        step();
        div_rst_n = 1'b1;
        cnt_rst_n = 1'b1;
    endtask

    // Sweep one select code with reload L for n cycles after reset
    task automatic sweep(input logic [1:0] s, input int L, input int n, input string req);
        reset_all(s);
        check(count, 0, req, "count after reset");
        for (int k = 0; k <= n; k++) begin
            check(tick, ((k % (L + 1)) == L) ? 1 : 0, req, "tick");
            check(count, (k / (L + 1)) % 16, "R6", "count");
            step();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);

        // R1: reset state and first strobe phase
        reset_all(2'b01);
        check(tick, 0, "R1", "tick after divider reset");
        check(count, 0, "R8", "count after counter reset");

        // R2 fast, R3 slow, R4 reserved codes; fast sweep runs past 16 strobes for R7
        sweep(2'b00, 1, 40, "R2");
        sweep(2'b01, 9, 45, "R3");
        sweep(2'b10, 1, 12, "R4");
        sweep(2'b11, 1, 12, "R4");

        // R7: explicit wrap from F to 0 with fast rate: after edge 32, 16 strobes taken
        reset_all(2'b00);
        for (int k = 0; k < 30; k++) step();
        check(count, 15, "R7", "count before wrap");
        check(tick, 0, "R7", "tick before wrap");
        step();
        check(tick, 1, "R7", "wrap strobe");
        step();
        check(count, 0, "R7", "count after wrap");

        // R9: slow countdown, switch to fast at k = 3
        reset_all(2'b01);
        for (int k = 0; k <= 14; k++) begin
            int exp_t;
            int exp_c;
            if (k == 3) rate_sel = 2'b00;
            exp_t = (k == 9 || k == 11 || k == 13) ? 1 : 0;
            exp_c = (k <= 9) ? 0 : (k <= 11) ? 1 : (k <= 13) ? 2 : 3;
            check(tick, exp_t, "R9", "tick across rate change");
            check(count, exp_c, "R9", "count across rate change");
            step();
        end

        // R8: counter reset coincident with a strobe wins, divider unaffected
        reset_all(2'b00);
        for (int k = 0; k < 5; k++) step();
        check(tick, 1, "R8", "strobe at k5");
        check(count, 2, "R8", "count at k5");
        cnt_rst_n = 1'b0;
        step();
        cnt_rst_n = 1'b1;
        for (int k = 6; k <= 12; k++) begin
            check(count, (k / 2) - 3, "R8", "count after counter reset");
            check(tick, k % 2, "R8", "tick unaffected by counter reset");
            step();
        end

        // R1: divider-only reset mid-count with new select; count kept
        reset_all(2'b01);
        for (int k = 0; k < 4; k++) step();
        rate_sel  = 2'b00;
        div_rst_n = 1'b0;
        step();
        div_rst_n = 1'b1;
        check(tick, 0, "R1", "tick after divider-only reset");
        check(count, 0, "R1", "count kept");
        step();
        check(tick, 1, "R1", "fast strobe after reload from new select");
        step();
        check(count, 1, "R1", "count stepped once");

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule